// File: doc/BRIEF.md
# Ordering Table Clear DMA Channel

This block is a single-purpose DMA channel that builds an empty, backward-linked list in RAM. Software programs a start address, a word count and a control word. Once the channel is armed and the per-channel master enable is set, it walks downward from the start address one 32-bit word at a time. Each word it writes holds the 24-bit address of the word just below it. The lowest word gets the end-of-list marker 0xFFFFFF. The block moves no data from anywhere; it only generates these contents.

Software reaches the channel through a simple register write port and a combinational read port. The channel registers sit at byte offsets 0x60 (start address), 0x64 (block word) and 0x68 (control), which is slot 6 at a 0x10 stride. The shared DMA control word sits at 0x70. Writes leave the block on a plain word-write master port with a valid/ready handshake. Software polls the control enable bit to learn when the list is finished.

Top module: `otc_dma_channel`

## Requirements
- R1: Each word written, except the last, goes to address A and holds (A - 4) masked to 24 bits. The first address is the programmed start, and each accepted write lowers the address by 4, wrapping modulo 2^24.
- R2: The last word of a transfer, at the lowest address, holds 0xFFFFFF.
- R3: The start-address register at offset 0x60 keeps only bits 23:0. Bits 31:24 of a write are ignored and read back as zero.
- R4: The word count is bits 15:0 of the block word at offset 0x64. A count of N writes N words, and a count of 0 writes 65536 words.
- R5: The control word is at offset 0x68, with enable/busy at bit 24 and the manual trigger at bit 28. A transfer starts only when both bits are set. Enable with the trigger clear, or the trigger with enable clear, writes nothing.
- R6: A transfer also needs the channel master enable, bit 27 of the shared word at offset 0x70. An armed channel waits while that bit is clear and starts once it is set. All other bits of the shared word read as zero.
- R7: When the last word has been accepted, control bit 24 reads back as 0.
- R8: Control bit 28 clears itself when the transfer starts.
- R9: Control bit 0 (direction) always reads 0 and bit 1 (step) always reads 1. Bits 8, 10:9, 18:16 and 22:20 read back as written. All other bits read as 0.
- R10: The memory port issues exactly one write per word. While valid is high and ready is low, the address and data hold steady.
- R11: Writes to the three channel registers are ignored while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | REG_AW | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | REG_AW | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 16-bit count and channel slot 6. At these values the full 65536-word case for a zero count runs end to end in the cycle budget. A bench memory model checks every word of every transfer against arithmetic on the start address. It covers short lists, a single-word list, a list that wraps below address zero, and a stalling ready pattern. Register sweeps cover arming combinations, readback masks, the master enable and writes attempted while the channel is busy.

// File: rtl/otc_pkg.sv
package otc_pkg;
   // control word bit positions (software-visible, decoded by the channel)
   localparam int CTL_DIR    = 0;
   localparam int CTL_STEP   = 1;
   localparam int CTL_CHOP   = 8;
   localparam int CTL_SYNC_L = 9;
   localparam int CTL_DWIN_L = 16;
   localparam int CTL_CWIN_L = 20;
   localparam int CTL_EN     = 24;
   localparam int CTL_TRIG   = 28;

   // register slot offsets inside a channel window
   localparam int OFS_BASE  = 0;
   localparam int OFS_BLOCK = 4;
   localparam int OFS_CTRL  = 8;
   localparam int CH_STRIDE = 16;

   typedef struct packed {
      logic       chop;
      logic [1:0] sync;
      logic [2:0] dwin;
      logic [2:0] cwin;
      logic       en;
      logic       trig;
   } ctl_t;

   function automatic logic [31:0] ctl_pack(input ctl_t c);
      logic [31:0] r;
      r = '0;
      r[CTL_DIR]                 = 1'b0;
      r[CTL_STEP]                = 1'b1;
      r[CTL_CHOP]                = c.chop;
      r[CTL_SYNC_L +: 2]         = c.sync;
      r[CTL_DWIN_L +: 3]         = c.dwin;
      r[CTL_CWIN_L +: 3]         = c.cwin;
      r[CTL_EN]                  = c.en;
      r[CTL_TRIG]                = c.trig;
      return r;
   endfunction
endpackage

// File: rtl/otc_regs.sv
module otc_regs
   import otc_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 16,
   parameter int CH_IDX     = 6,
   parameter int REG_AW     = 8,
   parameter int SHARED_OFS = 'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              busy_i,
   input  logic              done_i,
   output logic              start_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [CNT_W-1:0]  count_o
);
   localparam int MEN_BIT = 4 * CH_IDX + 3;
   localparam logic [REG_AW-1:0] A_BASE  = REG_AW'(CH_IDX * CH_STRIDE + OFS_BASE);
   localparam logic [REG_AW-1:0] A_BLOCK = REG_AW'(CH_IDX * CH_STRIDE + OFS_BLOCK);
   localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(CH_IDX * CH_STRIDE + OFS_CTRL);
   localparam logic [REG_AW-1:0] A_SHARE = REG_AW'(SHARED_OFS);

   logic [ADDR_W-1:0] base_q;
   logic [31:0]       blk_q;
   ctl_t              ctl_q;
   logic              men_q;

   assign start_o = ctl_q.en & ctl_q.trig & men_q & ~busy_i;
   assign base_o  = base_q;
   assign count_o = blk_q[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         blk_q  <= '0;
         ctl_q  <= '0;
         men_q  <= 1'b0;
      end else begin
         if (wr_en && !busy_i) begin
            if (wr_addr == A_BASE)  base_q <= wr_data[ADDR_W-1:0];
            if (wr_addr == A_BLOCK) blk_q  <= wr_data;
            if (wr_addr == A_CTRL) begin
               ctl_q.chop <= wr_data[CTL_CHOP];
               ctl_q.sync <= wr_data[CTL_SYNC_L +: 2];
               ctl_q.dwin <= wr_data[CTL_DWIN_L +: 3];
               ctl_q.cwin <= wr_data[CTL_CWIN_L +: 3];
               ctl_q.en   <= wr_data[CTL_EN];
               ctl_q.trig <= wr_data[CTL_TRIG];
            end
         end
         if (wr_en && wr_addr == A_SHARE) men_q <= wr_data[MEN_BIT];
         if (start_o) ctl_q.trig <= 1'b0;
         if (done_i)  ctl_q.en   <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_BASE)       rd_data = 32'(base_q);
      else if (rd_addr == A_BLOCK) rd_data = blk_q;
      else if (rd_addr == A_CTRL)  rd_data = ctl_pack(ctl_q);
      else if (rd_addr == A_SHARE) rd_data[MEN_BIT] = men_q;
   end

   // R8: trigger drops once the transfer is launched
   assert_trig_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !ctl_q.trig);
   // R7: enable/busy bit reads zero after the last accepted word
   assert_en_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !ctl_q.en);
   // R11: configuration frozen while the walker runs
   assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(base_q) && $stable(blk_q));
endmodule

// File: rtl/otc_walker.sv
module otc_walker #(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              mem_valid_o,
   input  logic              mem_ready_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [ADDR_W-1:0] mem_data_o
);
   localparam int REM_W = CNT_W + 1;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
   localparam logic [REM_W-1:0]  FULL = {1'b1, {CNT_W{1'b0}}};

   logic              busy_q;
   logic [ADDR_W-1:0] cur_q;
   logic [REM_W-1:0]  rem_q;
   logic              last;
   logic              accept;

   assign last        = (rem_q == REM_W'(1));
   assign accept      = busy_q & mem_ready_i;
   assign busy_o      = busy_q;
   assign done_o      = accept & last;
   assign mem_valid_o = busy_q;
   assign mem_addr_o  = cur_q;
   assign mem_data_o  = last ? {ADDR_W{1'b1}} : cur_q - STEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         rem_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cur_q  <= base_i;
         rem_q  <= (count_i == '0) ? FULL : {1'b0, count_i};
      end else if (accept) begin
         cur_q <= cur_q - STEP;
         rem_q <= rem_q - REM_W'(1);
         if (last) busy_q <= 1'b0;
      end
   end

   // R10: a stalled request holds address and data
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));
   // R1: after a non-final acceptance the next address is four lower
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !last |=> mem_valid_o && (mem_addr_o == $past(mem_addr_o) - STEP));
endmodule

// File: rtl/otc_dma_channel.sv
module otc_dma_channel #(
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 16,
   parameter int CH_IDX     = 6,
   parameter int REG_AW     = 8,
   parameter int SHARED_OFS = 'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_wr_addr,
   input  logic [31:0]       reg_wr_data,
   input  logic [REG_AW-1:0] reg_rd_addr,
   output logic [31:0]       reg_rd_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata
);
   generate
      if (ADDR_W < 8 || ADDR_W > 31) begin : g_bad_aw
         $error("ADDR_W must lie in 8..31");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cw
         $error("CNT_W must lie in 1..16");
      end
      if (CH_IDX < 0 || CH_IDX > 6) begin : g_bad_ch
         $error("CH_IDX must lie in 0..6");
      end
      if ((1 << REG_AW) <= SHARED_OFS || (1 << REG_AW) <= CH_IDX * 16 + 8) begin : g_bad_ra
         $error("REG_AW too narrow for the register offsets");
      end
   endgenerate

   logic              start;
   logic              walk_busy;
   logic              walk_done;
   logic [ADDR_W-1:0] base;
   logic [CNT_W-1:0]  count;
   logic [ADDR_W-1:0] data_w;

   otc_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_IDX(CH_IDX),
      .REG_AW(REG_AW), .SHARED_OFS(SHARED_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .busy_i(walk_busy), .done_i(walk_done), .start_o(start),
      .base_o(base), .count_o(count)
   );

   otc_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .base_i(base), .count_i(count),
      .busy_o(walk_busy), .done_o(walk_done),
      .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
      .mem_addr_o(mem_addr), .mem_data_o(data_w)
   );

   assign mem_wdata = {{(32 - ADDR_W){1'b0}}, data_w};

   // R2: the final accepted word carries the terminator
   assert_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> mem_wdata == {{(32 - ADDR_W){1'b0}}, {ADDR_W{1'b1}}});
   // R5 R6: a walk begins only from an armed, master-enabled channel
   assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(walk_busy) |-> $past(u_regs.ctl_q.en && u_regs.ctl_q.trig && u_regs.men_q));
endmodule

// File: tb/otc_dma_channel_test.sv
module otc_dma_channel_test;
   localparam int CLK_NS = 10;
   localparam logic [7:0] A_BASE = 8'h60, A_BLK = 8'h64, A_CTL = 8'h68, A_SHR = 8'h70;
   localparam logic [31:0] EN = 32'h0100_0000, TRIG = 32'h1000_0000, MEN = 32'h0800_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr_en = 1'b0;
   logic [7:0] reg_wr_addr = '0, reg_rd_addr = '0;
   logic [31:0] reg_wr_data = '0, reg_rd_data;
   logic mem_valid, mem_ready;
   logic [23:0] mem_addr;
   logic [31:0] mem_wdata;

   int errors = 0, checks = 0;
   int cyc = 0;
   logic stall = 1'b0;
   logic [23:0] exp_addr = '0;
   int exp_left = 0, words = 0, mon_err = 0;
   logic prev_stall = 1'b0;
   logic [23:0] prev_addr = '0;
   logic [31:0] prev_data = '0;
   bit finished = 0;

   always #(CLK_NS / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   assign mem_ready = stall ? (cyc % 3 != 0) : 1'b1;

   otc_dma_channel uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   // memory model: every accepted word against arithmetic on the start address
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall && !(mem_valid && mem_addr == prev_addr && mem_wdata == prev_data)) begin
            mon_err++;
            $display("  mismatch R10: stalled request changed");
         end
         if (mem_valid && mem_ready) begin
            if (exp_left == 0) begin
               mon_err++;
               $display("  mismatch: unexpected write addr=%h", mem_addr);
            end else begin
               logic [31:0] ed;
               ed = (exp_left == 1) ? 32'h00FF_FFFF : {8'h0, exp_addr - 24'd4};
               if (mem_addr != exp_addr || mem_wdata != ed) begin
                  mon_err++;
                  if (mon_err < 5)
                     $display("  mismatch R1/R2: addr=%h data=%h want addr=%h data=%h",
                              mem_addr, mem_wdata, exp_addr, ed);
               end
               exp_addr = exp_addr - 24'd4;
               exp_left--;
               words++;
            end
         end
         prev_stall = mem_valid && !mem_ready;
         prev_addr  = mem_addr;
         prev_data  = mem_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd_addr = a;
      #1 d = reg_rd_data;
   endtask

   task automatic arm(input logic [31:0] base, input int cnt);
      exp_addr = base[23:0];
      exp_left = (cnt == 0) ? 65536 : cnt;
      words = 0; mon_err = 0;
   endtask

   task automatic wait_idle(output logic [31:0] c);
      c = EN;
      for (int i = 0; i < 150000 && c[24]; i++) rd(A_CTL, c);
   endtask

   task automatic run(input string req, input logic [31:0] base, input int cnt, input logic [31:0] extra);
      logic [31:0] c;
      int want;
      want = (cnt == 0) ? 65536 : cnt;
      wr(A_BASE, base);
      wr(A_BLK, 32'(cnt));
      arm(base, cnt);
      wr(A_CTL, EN | TRIG | extra);
      wait_idle(c);
      repeat (3) @(negedge clk);
      check(words == want && mon_err == 0, req, 32'(words), 32'(want));
      check(c[24] == 1'b0, {req, " R7 enable cleared"}, c, c & ~EN);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd(A_CTL, v);  check(v == 32'h2, "R9 reset control", v, 32'h2);
      rd(A_BASE, v); check(v == 0, "R3 reset base", v, 0);
      rd(A_SHR, v);  check(v == 0, "R6 reset shared", v, 0);
      wr(A_SHR, 32'hFFFF_FFFF);
      rd(A_SHR, v);  check(v == MEN, "R6 shared mask", v, MEN);

      run("R1 R2 four words", 32'h0000_1000, 4, 0);
      run("R2 single word", 32'h0000_2000, 1, 0);
      run("R1 wrap below zero", 32'h0000_0004, 3, 0);
      run("R3 high base bits ignored", 32'hAB00_0010, 2, 0);
      rd(A_BASE, v); check(v == 32'h10, "R3 base readback", v, 32'h10);

      // R9 readback of kept and forced fields
      run("R9 transfer with extras", 32'h0000_3000, 5, 32'h4077_0701);
      rd(A_CTL, v); check(v == 32'h0077_0702, "R9 R8 control after run", v, 32'h0077_0702);

      // R8 trigger gone once running
      stall = 1'b1;
      wr(A_BASE, 32'h0000_4000); wr(A_BLK, 32'd12); arm(32'h4000, 12);
      wr(A_CTL, EN | TRIG);
      repeat (2) @(negedge clk);
      rd(A_CTL, v); check(v[28] == 0 && v[24] == 1, "R8 trigger self-clear", v, 32'h0100_0002);
      // R11 writes ignored while running
      wr(A_BASE, 32'h0000_7770);
      wr(A_BLK, 32'd3);
      wait_idle(v);
      repeat (3) @(negedge clk);
      check(words == 12 && mon_err == 0, "R10 R11 stalled run", 32'(words), 32'd12);
      rd(A_BASE, v); check(v == 32'h4000, "R11 base kept", v, 32'h4000);
      rd(A_BLK, v);  check(v == 32'd12, "R11 block kept", v, 32'd12);
      stall = 1'b0;

      // R5 enable alone / trigger alone
      wr(A_BASE, 32'h5000); wr(A_BLK, 32'd2); arm(32'h5000, 0); exp_left = 0;
      wr(A_CTL, EN);
      repeat (20) @(negedge clk);
      check(words == 0 && mon_err == 0, "R5 automatic mode idle", 32'(words), 0);
      rd(A_CTL, v); check(v == (EN | 32'h2), "R5 enable held", v, EN | 32'h2);
      wr(A_CTL, TRIG);
      repeat (20) @(negedge clk);
      check(words == 0 && mon_err == 0, "R5 trigger alone idle", 32'(words), 0);
      rd(A_CTL, v); check(v == (TRIG | 32'h2), "R5 trigger held", v, TRIG | 32'h2);

      // R6 master enable gates and releases
      wr(A_SHR, 0);
      arm(32'h5000, 2);
      wr(A_CTL, EN | TRIG);
      repeat (20) @(negedge clk);
      check(words == 0, "R6 master off holds", 32'(words), 0);
      rd(A_CTL, v); check(v == (EN | TRIG | 32'h2), "R6 pending armed", v, EN | TRIG | 32'h2);
      wr(A_SHR, MEN);
      wait_idle(v);
      repeat (3) @(negedge clk);
      check(words == 2 && mon_err == 0, "R6 released", 32'(words), 2);

      // R4 zero count means full range
      run("R4 zero count", 32'h0004_0000, 0, 0);
      run("R4 count 7", 32'h0000_0100, 7, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule